// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the storage and arithmetic half of a small memory-to-memory processor. Every register, every functional unit and the word memory meet on one 32-bit internal bus. An external sequencer picks the bus source each cycle with a one-hot drive vector and picks any number of destinations with a load vector. On the next rising edge, provided the clock-enable input is high, each selected destination captures the bus value.

The sequencer builds instructions from these cycles. It fetches through the address register and advances the program counter with the built-in incrementer. It moves operands from memory into the two operand registers. It then drives a functional unit's result back to memory, or loads the program counter from an argument register when the equal or less-than flag calls for a branch. The multiply and divide units are purely combinational, so a sequencer that waits extra cycles for them always sees a settled result. A test-only backdoor port preloads the memory.

Top module: `sbus_datapath`

## Requirements
- R1: The active-low asynchronous reset clears the program counter, both operand registers, the opcode register, the three argument registers and the address register to zero.
- R2: The drive vector maps bit 0 to PC, 1 to PC+1, 2 to sum, 3 to difference, 4 to product, 5 to quotient, 6 to AND, 7 to OR, 8 to NOT, 9 to left shift, 10 to right shift, 11 to 13 to argument registers 1 to 3, and 14 to memory read data. With no bit set, the bus is zero.
- R3: With more than one drive bit set, the bus carries the bitwise OR of the selected sources and multi_drive_o is 1. With zero or one bit set, multi_drive_o is 0.
- R4: The PC+1 source is always PC plus one, modulo 2^32. Loading PC and the address register from it in one cycle leaves both holding the new value.
- R5: eq_o is 1 when operand 1 equals operand 2. lt_o is 1 when operand 1 is below operand 2 as signed two's-complement numbers.
- R6: The load vector maps bit 0 to PC, 1 to operand 1, 2 to operand 2, 3 to the opcode, 4 to 6 to argument registers 1 to 3, 7 to the address register and 8 to memory. Every selected destination captures the bus value at the rising edge. opcode_o shows the opcode register.
- R7: Memory read data is the word at the low 8 bits of the address register. A memory load writes the bus value to that word.
- R8: Sum, difference and product are the low 32 bits of the result. The quotient is the unsigned operand 1 divided by operand 2, and all ones when operand 2 is zero.
- R9: The AND and OR sources combine the two operands bitwise. The NOT source is the bitwise inverse of operand 1 alone.
- R10: The shift sources shift operand 1 left or logically right by the full unsigned value of operand 2. An amount of 32 or more gives zero.
- R11: While clk_en_i is 0, no register and no memory word changes.
- R12: A backdoor write stores bd_data_i at bd_addr_i on a rising edge with clk_en_i high. It takes priority over a bus write to memory in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock-valid qualifier for every state update |
| drive_i | input | 15 | One-hot bus source select |
| load_i | input | 9 | Bus destination write enables |
| bd_we_i | input | 1 | Backdoor memory write enable |
| bd_addr_i | input | 8 | Backdoor memory word address |
| bd_data_i | input | 32 | Backdoor memory write data |
| bus_o | output | 32 | Current internal bus value |
| opcode_o | output | 32 | Opcode register contents |
| eq_o | output | 1 | Operand 1 equals operand 2 |
| lt_o | output | 1 | Operand 1 is signed-less-than operand 2 |
| multi_drive_o | output | 1 | More than one bus source selected |

## Verification
The bench focuses on operand pairs where one flaw shows up clearly. Equal operands catch inverted flags. A negative operand 1 against a positive operand 2 separates a signed comparison from an unsigned one, and also catches an arithmetic right shift in place of a logical one. A zero divisor would otherwise give a simulator-dependent quotient instead of all ones. A shift amount of 40 would wrap to 8 in a design that masks the amount to five bits. Several steps combine the incrementer with simultaneous PC and address loads, where a design that fed memory from the stale address would fetch the wrong word. Two further cases are a multi-drive bus that must OR its sources, and a stalled clock-enable cycle with PC, opcode and memory loads requested that must change nothing.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int SRC_N = 15;
  localparam int DST_N = 9;

  // bus source bit positions
  localparam int S_PC     = 0;
  localparam int S_PC_INC = 1;
  localparam int S_ADD    = 2;
  localparam int S_SUB    = 3;
  localparam int S_MUL    = 4;
  localparam int S_DIV    = 5;
  localparam int S_AND    = 6;
  localparam int S_OR     = 7;
  localparam int S_NOT    = 8;
  localparam int S_SHL    = 9;
  localparam int S_SHR    = 10;
  localparam int S_ARG1   = 11;
  localparam int S_ARG2   = 12;
  localparam int S_ARG3   = 13;
  localparam int S_MEM    = 14;

  // bus destination bit positions
  localparam int L_PC   = 0;
  localparam int L_OP1  = 1;
  localparam int L_OP2  = 2;
  localparam int L_OPC  = 3;
  localparam int L_ARG1 = 4;
  localparam int L_ARG2 = 5;
  localparam int L_ARG3 = 6;
  localparam int L_MAR  = 7;
  localparam int L_MEM  = 8;

  typedef logic [SRC_N-1:0] drv_t;
  typedef logic [DST_N-1:0] ld_t;

  localparam drv_t D_PC     = drv_t'(1) << S_PC;
  localparam drv_t D_PC_INC = drv_t'(1) << S_PC_INC;
  localparam drv_t D_ADD    = drv_t'(1) << S_ADD;
  localparam drv_t D_MUL    = drv_t'(1) << S_MUL;
  localparam drv_t D_ARG1   = drv_t'(1) << S_ARG1;
  localparam drv_t D_ARG2   = drv_t'(1) << S_ARG2;
  localparam drv_t D_ARG3   = drv_t'(1) << S_ARG3;
  localparam drv_t D_MEM    = drv_t'(1) << S_MEM;

  localparam ld_t LD_PC   = ld_t'(1) << L_PC;
  localparam ld_t LD_OP1  = ld_t'(1) << L_OP1;
  localparam ld_t LD_OP2  = ld_t'(1) << L_OP2;
  localparam ld_t LD_OPC  = ld_t'(1) << L_OPC;
  localparam ld_t LD_ARG1 = ld_t'(1) << L_ARG1;
  localparam ld_t LD_ARG2 = ld_t'(1) << L_ARG2;
  localparam ld_t LD_ARG3 = ld_t'(1) << L_ARG3;
  localparam ld_t LD_MAR  = ld_t'(1) << L_MAR;
  localparam ld_t LD_MEM  = ld_t'(1) << L_MEM;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ARG_N  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [DST_N-1:0]          ld_i,
  input  logic [DW-1:0]             bus_i,
  output logic [DW-1:0]             pc_o,
  output logic [DW-1:0]             op1_o,
  output logic [DW-1:0]             op2_o,
  output logic [DW-1:0]             opc_o,
  output logic [ARG_N-1:0][DW-1:0]  arg_o,
  output logic [DW-1:0]             mar_o
);
  logic [DW-1:0] pc_q, op1_q, op2_q, opc_q, mar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      op1_q <= '0;
      op2_q <= '0;
      opc_q <= '0;
      mar_q <= '0;
    end else if (en_i) begin
      if (ld_i[L_PC])  pc_q  <= bus_i;
      if (ld_i[L_OP1]) op1_q <= bus_i;
      if (ld_i[L_OP2]) op2_q <= bus_i;
      if (ld_i[L_OPC]) opc_q <= bus_i;
      if (ld_i[L_MAR]) mar_q <= bus_i;
    end
  end

  for (genvar g = 0; g < ARG_N; g++) begin : g_arg
    logic [DW-1:0] arg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        arg_q <= '0;
      else if (en_i && ld_i[L_ARG1 + g])  arg_q <= bus_i;
    end
    assign arg_o[g] = arg_q;
  end

  assign pc_o  = pc_q;
  assign op1_o = op1_q;
  assign op2_o = op2_q;
  assign opc_o = opc_q;
  assign mar_o = mar_q;
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] op1_i,
  input  logic [DW-1:0] op2_i,
  output logic [DW-1:0] pc_inc_o,
  output logic [DW-1:0] add_o,
  output logic [DW-1:0] sub_o,
  output logic [DW-1:0] mul_o,
  output logic [DW-1:0] div_o,
  output logic [DW-1:0] and_o,
  output logic [DW-1:0] or_o,
  output logic [DW-1:0] not_o,
  output logic [DW-1:0] shl_o,
  output logic [DW-1:0] shr_o,
  output logic          eq_o,
  output logic          lt_o
);
  assign pc_inc_o = pc_i + DW'(1);
  assign add_o    = op1_i + op2_i;
  assign sub_o    = op1_i - op2_i;
  assign mul_o    = op1_i * op2_i;
  // zero divisor saturates to all ones
  assign div_o    = (op2_i == '0) ? '1 : op1_i / op2_i;
  assign and_o    = op1_i & op2_i;
  assign or_o     = op1_i | op2_i;
  assign not_o    = ~op1_i;
  // full-width amount: >= DW clears the result
  assign shl_o    = op1_i << op2_i;
  assign shr_o    = op1_i >> op2_i;
  assign eq_o     = (op1_i == op2_i);
  assign lt_o     = ($signed(op1_i) < $signed(op2_i));
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem #(
  parameter int DW    = 32,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bd_we_i,
  input  logic [AW-1:0] bd_addr_i,
  input  logic [DW-1:0] bd_data_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [AW-1:0] idx;
  logic          unused_addr_hi;

  assign idx            = addr_i[AW-1:0];
  assign unused_addr_hi = ^addr_i[DW-1:AW];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (bd_we_i)   mem_q[bd_addr_i] <= bd_data_i;
      else if (we_i) mem_q[idx]       <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx];
endmodule

// File: rtl/sbus_busmux.sv
module sbus_busmux #(
  parameter int DW = 32,
  parameter int N  = 15
) (
  input  logic [N-1:0]         sel_i,
  input  logic [N-1:0][DW-1:0] src_i,
  output logic [DW-1:0]        bus_o,
  output logic                 multi_o
);
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) bus_o = bus_o | src_i[i];
    end
  end

  // nonzero after clearing the lowest set bit => two or more set
  assign multi_o = |(sel_i & (sel_i - N'(1)));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256,
  localparam int ADDR_W   = $clog2(MEM_WORDS),
  localparam int ARG_N    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [SRC_N-1:0]  drive_i,
  input  logic [DST_N-1:0]  load_i,
  input  logic              bd_we_i,
  input  logic [ADDR_W-1:0] bd_addr_i,
  input  logic [DATA_W-1:0] bd_data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              eq_o,
  output logic              lt_o,
  output logic              multi_drive_o
);
  logic [DATA_W-1:0]            bus;
  logic [DATA_W-1:0]            pc_q, op1_q, op2_q, opc_q, mar_q, mem_rd;
  logic [ARG_N-1:0][DATA_W-1:0] arg_q;
  logic [SRC_N-1:0][DATA_W-1:0] src;

  sbus_regfile #(.DW(DATA_W), .ARG_N(ARG_N)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (clk_en_i),
    .ld_i  (load_i),
    .bus_i (bus),
    .pc_o  (pc_q),
    .op1_o (op1_q),
    .op2_o (op2_q),
    .opc_o (opc_q),
    .arg_o (arg_q),
    .mar_o (mar_q)
  );

  sbus_alu #(.DW(DATA_W)) u_alu (
    .pc_i    (pc_q),
    .op1_i   (op1_q),
    .op2_i   (op2_q),
    .pc_inc_o(src[S_PC_INC]),
    .add_o   (src[S_ADD]),
    .sub_o   (src[S_SUB]),
    .mul_o   (src[S_MUL]),
    .div_o   (src[S_DIV]),
    .and_o   (src[S_AND]),
    .or_o    (src[S_OR]),
    .not_o   (src[S_NOT]),
    .shl_o   (src[S_SHL]),
    .shr_o   (src[S_SHR]),
    .eq_o    (eq_o),
    .lt_o    (lt_o)
  );

  sbus_mem #(.DW(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk_i    (clk_i),
    .en_i     (clk_en_i),
    .we_i     (load_i[L_MEM]),
    .addr_i   (mar_q),
    .wdata_i  (bus),
    .bd_we_i  (bd_we_i),
    .bd_addr_i(bd_addr_i),
    .bd_data_i(bd_data_i),
    .rdata_o  (mem_rd)
  );

  assign src[S_PC]  = pc_q;
  assign src[S_MEM] = mem_rd;
  for (genvar g = 0; g < ARG_N; g++) begin : g_arg_src
    assign src[S_ARG1 + g] = arg_q[g];
  end

  sbus_busmux #(.DW(DATA_W), .N(SRC_N)) u_mux (
    .sel_i  (drive_i),
    .src_i  (src),
    .bus_o  (bus),
    .multi_o(multi_drive_o)
  );

  assign bus_o    = bus;
  assign opcode_o = opc_q;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk
  import sbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic [SRC_N-1:0]  drive_i,
  input logic [DST_N-1:0]  load_i,
  input logic [DATA_W-1:0] bus_o,
  input logic [DATA_W-1:0] opcode_o,
  input logic              eq_o,
  input logic              lt_o,
  input logic              multi_drive_o,
  input logic [DATA_W-1:0] pc_i
);
  a_r2_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i == '0) |-> (bus_o == '0));

  a_r3_no_false_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_i) |-> !multi_drive_o);

  a_r5_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eq_o && lt_o));

  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && load_i[L_PC] && drive_i == D_PC_INC) |=> (pc_i == $past(pc_i) + DATA_W'(1)));

  a_r6_opcode_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && load_i[L_OPC]) |=> (opcode_o == $past(bus_o)));

  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(pc_i) && $stable(opcode_o)));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_en_i     (clk_en_i),
  .drive_i      (drive_i),
  .load_i       (load_i),
  .bus_o        (bus_o),
  .opcode_o     (opcode_o),
  .eq_o         (eq_o),
  .lt_o         (lt_o),
  .multi_drive_o(multi_drive_o),
  .pc_i         (pc_q)
);

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
  import sbus_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b1;
  drv_t        drive_i = '0;
  ld_t         load_i = '0;
  logic        bd_we_i = 1'b0;
  logic [7:0]  bd_addr_i = '0;
  logic [31:0] bd_data_i = '0;
  logic [31:0] bus_o, opcode_o;
  logic        eq_o, lt_o, multi_drive_o;

  int vectors = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_pc, m_op1, m_op2, m_opc, m_mar;
  logic [31:0] m_arg [3];
  logic [31:0] m_mem [256];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sbus_datapath uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i),
    .drive_i(drive_i), .load_i(load_i),
    .bd_we_i(bd_we_i), .bd_addr_i(bd_addr_i), .bd_data_i(bd_data_i),
    .bus_o(bus_o), .opcode_o(opcode_o), .eq_o(eq_o), .lt_o(lt_o),
    .multi_drive_o(multi_drive_o)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] src_val(int i);
    case (i)
      S_PC:     return m_pc;
      S_PC_INC: return m_pc + 1;
      S_ADD:    return m_op1 + m_op2;
      S_SUB:    return m_op1 - m_op2;
      S_MUL:    return 32'((64'(m_op1) * 64'(m_op2)) & 64'hFFFF_FFFF);
      S_DIV:    return (m_op2 == 0) ? 32'hFFFF_FFFF : m_op1 / m_op2;
      S_AND:    return m_op1 & m_op2;
      S_OR:     return m_op1 | m_op2;
      S_NOT:    return ~m_op1;
      S_SHL:    return (m_op2 >= 32) ? 32'h0 : m_op1 << m_op2[4:0];
      S_SHR:    return (m_op2 >= 32) ? 32'h0 : m_op1 >> m_op2[4:0];
      S_ARG1:   return m_arg[0];
      S_ARG2:   return m_arg[1];
      S_ARG3:   return m_arg[2];
      default:  return m_mem[m_mar[7:0]];
    endcase
  endfunction

  function automatic logic [31:0] exp_bus(drv_t d);
    logic [31:0] r = '0;
    for (int i = 0; i < SRC_N; i++) if (d[i]) r = r | src_val(i);
    return r;
  endfunction

  function automatic string req_of(int i);
    case (i)
      S_ADD, S_SUB, S_MUL, S_DIV: return "R8 arith";
      S_AND, S_OR, S_NOT:         return "R9 logic";
      default:                    return "R10 shift";
    endcase
  endfunction

  task automatic model_reset();
    m_pc = '0; m_op1 = '0; m_op2 = '0; m_opc = '0; m_mar = '0;
    for (int i = 0; i < 3; i++) m_arg[i] = '0;
  endtask

  task automatic step(drv_t d, ld_t l, logic en, string req);
    logic [31:0] eb;
    int ones;
    @(negedge clk_i);
    drive_i = d; load_i = l; clk_en_i = en; bd_we_i = 1'b0;
    #(CLK_PERIOD/4);
    eb = exp_bus(d);
    ones = $countones(d);
    chk(req, bus_o, eb);
    chk("R5 eq flag", 32'(eq_o), 32'(m_op1 == m_op2));
    chk("R5 lt flag", 32'(lt_o), 32'($signed(m_op1) < $signed(m_op2)));
    chk("R3 multi flag", 32'(multi_drive_o), 32'(ones > 1));
    chk("R6 opcode", opcode_o, m_opc);
    @(posedge clk_i);
    if (en) begin
      if (l[L_MEM])  m_mem[m_mar[7:0]] = eb;
      if (l[L_PC])   m_pc = eb;
      if (l[L_OP1])  m_op1 = eb;
      if (l[L_OP2])  m_op2 = eb;
      if (l[L_OPC])  m_opc = eb;
      if (l[L_ARG1]) m_arg[0] = eb;
      if (l[L_ARG2]) m_arg[1] = eb;
      if (l[L_ARG3]) m_arg[2] = eb;
      if (l[L_MAR])  m_mar = eb;
    end
  endtask

  task automatic preload(logic [7:0] a, logic [31:0] v);
    @(negedge clk_i);
    drive_i = '0; load_i = '0; clk_en_i = 1'b1;
    bd_we_i = 1'b1; bd_addr_i = a; bd_data_i = v;
    @(posedge clk_i);
    m_mem[a] = v;
    #1 bd_we_i = 1'b0;
  endtask

  task automatic sweep_alu();
    for (int i = S_ADD; i <= S_SHR; i++) step(drv_t'(1) << i, '0, 1'b1, req_of(i));
  endtask

  task automatic set_ops(logic [31:0] a, logic [31:0] b);
    preload(m_mar[7:0], a);
    step(D_MEM, LD_OP1, 1'b1, "R7 operand 1 read");
    preload(m_mar[7:0], b);
    step(D_MEM, LD_OP2, 1'b1, "R7 operand 2 read");
    sweep_alu();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    step(D_PC, '0, 1'b1, "R1 pc after reset");
    step(D_ARG2, '0, 1'b1, "R1 arg2 after reset");
    step('0, '0, 1'b1, "R2 idle bus");

    // instruction fetch through the address register
    preload(8'd0, 32'h5);
    preload(8'd1, 32'h20);
    preload(8'd2, 32'h21);
    preload(8'd3, 32'h22);
    step(D_MEM, '0, 1'b1, "R12 backdoor readback");
    step(D_PC, LD_MAR, 1'b1, "R7 pc to address");
    step(D_MEM, LD_OPC, 1'b1, "R7 opcode read");
    step(D_PC_INC, LD_PC | LD_MAR, 1'b1, "R4 advance 1");
    step(D_MEM, LD_ARG1, 1'b1, "R7 arg1 read");
    step(D_PC_INC, LD_PC | LD_MAR, 1'b1, "R4 advance 2");
    step(D_MEM, LD_ARG2, 1'b1, "R7 arg2 read");
    step(D_PC_INC, LD_PC | LD_MAR, 1'b1, "R4 advance 3");
    step(D_MEM, LD_ARG3, 1'b1, "R7 arg3 read");
    step(D_PC_INC, LD_PC, 1'b1, "R4 advance 4");
    step(D_PC, '0, 1'b1, "R4 pc value");
    step(D_ARG1, '0, 1'b1, "R6 arg1 value");
    step(D_ARG3, '0, 1'b1, "R6 arg3 value");

    // operand fetch and result write-back
    preload(8'h21, 32'd7);
    preload(8'h22, 32'hFFFF_FFF9);
    step(D_ARG2, LD_MAR, 1'b1, "R6 arg2 to address");
    step(D_MEM, LD_OP1, 1'b1, "R7 operand 1");
    step(D_ARG3, LD_MAR, 1'b1, "R6 arg3 to address");
    step(D_MEM, LD_OP2, 1'b1, "R7 operand 2");
    sweep_alu();
    step(D_ARG1, LD_MAR, 1'b1, "R6 arg1 to address");
    step(D_MUL, LD_MEM, 1'b1, "R8 product to memory");
    step(D_MEM, '0, 1'b1, "R7 write readback");

    // corner operand pairs
    set_ops(32'd7, 32'd7);
    set_ops(32'hFFFF_FFFD, 32'd5);
    set_ops(32'd100, 32'd0);
    set_ops(32'h8000_0001, 32'd4);
    set_ops(32'd1, 32'd40);
    set_ops(32'd5, 32'hFFFF_FFFF);
    set_ops(32'h1234_5678, 32'd31);

    // overlapping drivers
    step(D_ARG1 | D_ARG2, '0, 1'b1, "R3 OR of two");
    step(D_ARG1 | D_ARG2 | D_PC, LD_ARG3, 1'b1, "R3 OR of three");
    step(D_ARG3, '0, 1'b1, "R3 captured OR");

    // stalled clock-enable
    step(D_PC_INC, LD_PC | LD_OPC | LD_MEM | LD_OP1, 1'b0, "R11 stalled cycle");
    step(D_PC, '0, 1'b1, "R11 pc held");
    step(D_MEM, '0, 1'b1, "R11 memory held");
    step(D_ADD, '0, 1'b1, "R11 operands held");

    // asynchronous reset mid-run
    step('0, '0, 1'b1, "R2 idle before reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2 rst_ni = 1'b1;
    model_reset();
    step(D_PC, '0, 1'b1, "R1 pc cleared");
    step(D_ARG1, '0, 1'b1, "R1 arg1 cleared");
    step(D_ADD, '0, 1'b1, "R1 operands cleared");
    step('0, '0, 1'b1, "R2 idle at end");

    report();
  end
endmodule